// File: doc/BRIEF.md
# Head Stepper Phase Decoder

This block sits behind an 8-bit output port that drives a disk-drive read/write head. Software writes a byte to the port. The two low bits of that byte set the energised phase of the head stepper motor, and bit 3 switches an activity lamp. The block keeps the port value. On every write it compares the previous phase with the new one and turns the difference into a one-cycle step-in or step-out pulse for the head mechanics. It also flags whether the lamp bit toggled.

Phases are treated as a ring of four positions, so motion wraps between 3 and 0. Only a move to a neighbouring position on the ring counts as a step. A jump to the opposite phase gives no step, and so does rewriting the same phase. The stored byte always has bit 4 cleared. The block counts no position and times no motor.

Top module: `head_step_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `port_q` to 0x00 and drives `step_in`, `step_out`, `led_changed` and `led` low.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data` with bit 4 forced to 0 into `port_q`, visible right after that edge. Without a write, `port_q` holds its value.
- R3: When the stored phase (`port_q[1:0]`) equals (written phase + 1) mod 4, `step_out` is high for the cycle after the write. Examples are 1→0 and 0→3.
- R4: When the stored phase equals (written phase − 1) mod 4, `step_in` is high for the cycle after the write. Examples are 0→1 and 3→0.
- R5: A write whose phase equals the stored phase, or differs from it by 2, leaves both `step_in` and `step_out` low.
- R6: `led_changed` is high for the cycle after a write whose bit 3 differs from the stored bit 3. `led` always shows the stored bit 3.
- R7: `step_in`, `step_out` and `led_changed` are low in any cycle that does not directly follow a write, so each pulse lasts exactly one cycle.
- R8: `step_in` and `step_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Port write strobe |
| wr_data | input | 8 | Byte written to the port |
| port_q | output | 8 | Stored port value, bit 4 always 0 |
| step_in | output | 1 | One-cycle pulse: head steps inward |
| step_out | output | 1 | One-cycle pulse: head steps outward |
| led | output | 1 | Activity lamp level (stored bit 3) |
| led_changed | output | 1 | One-cycle pulse: lamp bit toggled |

## Verification
The hardest case to reach is the pair of wrap-around steps across the 3/0 boundary, checked in both directions, together with back-to-back writes. In that sequence each pulse must be computed from the value stored by the write just before it, so no idle cycle is left between writes. The stimulus walks the phase ring in both directions and keeps the strobe high for consecutive writes. It then inserts opposite-phase jumps and repeated phases, and finishes with a long run of pseudo-random bytes with random gaps. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/head_step_decoder.sv
module head_step_decoder #(
  parameter int PORT_W    = 8,
  parameter int PHASE_LO  = 0,
  parameter int LED_POS   = 3,
  parameter int ZERO_POS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] port_q,
  output logic              step_in,
  output logic              step_out,
  output logic              led,
  output logic              led_changed
);

  localparam logic [PORT_W-1:0] KEEP_MASK = ~(PORT_W'(1) << ZERO_POS);

  logic [1:0] phase_old, phase_new;
  logic       moved, go_out, go_in, lamp_flip;

  assign phase_old = port_q[PHASE_LO +: 2];
  assign phase_new = wr_data[PHASE_LO +: 2];
  assign moved     = phase_old != phase_new;
  assign go_out    = moved && (phase_old == 2'(phase_new + 2'd1));
  assign go_in     = moved && (phase_old == 2'(phase_new - 2'd1));
  assign lamp_flip = port_q[LED_POS] != wr_data[LED_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q      <= '0;
      step_in     <= 1'b0;
      step_out    <= 1'b0;
      led_changed <= 1'b0;
    end else begin
      step_in     <= wr_en && go_in;
      step_out    <= wr_en && go_out;
      led_changed <= wr_en && lamp_flip;
      if (wr_en)
        port_q <= wr_data & KEEP_MASK;
    end
  end

  assign led = port_q[LED_POS];

endmodule

// File: rtl/head_step_decoder_chk.sv
module head_step_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] port_q,
  input logic       step_in,
  input logic       step_out,
  input logic       led,
  input logic       led_changed
);

  a_r2_bit4_zero: assert property (@(posedge clk) disable iff (rst)
    !port_q[4]);

  a_r2_store: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> port_q == ($past(wr_data) & 8'hEF));

  a_r3_step_out: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) &&
     $past(port_q[1:0]) == 2'($past(wr_data[1:0]) + 2'd1)) |-> step_out);

  a_r4_step_in: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) &&
     $past(port_q[1:0]) == 2'($past(wr_data[1:0]) - 2'd1)) |-> step_in);

  a_r6_led_toggle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(port_q[3]) != $past(wr_data[3]))
      |-> (led_changed && led == $past(wr_data[3])));

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> (!step_in && !step_out && !led_changed));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(step_in && step_out));

endmodule

bind head_step_decoder head_step_decoder_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .port_q(port_q), .step_in(step_in), .step_out(step_out),
  .led(led), .led_changed(led_changed)
);

// File: tb/tb_head_step_decoder.sv
`timescale 1ns/1ps
module tb_head_step_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] port_q;
  logic       step_in, step_out, led, led_changed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_port = 0, m_in = 0, m_out = 0, m_chg = 0;

  always #5 clk = ~clk;

  head_step_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .port_q(port_q), .step_in(step_in), .step_out(step_out),
    .led(led), .led_changed(led_changed)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int po, pn, d;
    d  = int'(wr_data);
    po = m_port % 4;
    pn = d % 4;
    if (rst) begin
      m_port = 0; m_in = 0; m_out = 0; m_chg = 0;
    end else if (wr_en) begin
      m_out = (pn != po && po == (pn + 1) % 4) ? 1 : 0;
      m_in  = (pn != po && po == (pn + 3) % 4) ? 1 : 0;
      m_chg = (((m_port / 8) % 2) != ((d / 8) % 2)) ? 1 : 0;
      m_port = (d / 32) * 32 + (d % 16);
    end else begin
      m_in = 0; m_out = 0; m_chg = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R2", "port_q", int'(port_q), m_port);
      check("R3", "step_out", int'(step_out), m_out);
      check("R4", "step_in", int'(step_in), m_in);
      check("R6", "led_changed", int'(led_changed), m_chg);
      check("R6", "led", int'(led), (m_port / 8) % 2);
      check("R8", "step exclusive", int'(step_in && step_out), 0);
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    idle(3);
    rst = 1'b0;
    // R1: reset state
    check("R1", "port_q reset", int'(port_q), 0);
    check("R1", "pulses reset", int'({step_in, step_out, led_changed, led}), 0);
    // R4 walk inward across wrap, back-to-back
    wr_en = 1'b1;
    wr_data = 8'h01; @(negedge clk);
    check("R4", "0->1 step_in", int'(step_in), 1);
    wr_data = 8'h02; @(negedge clk);
    wr_data = 8'h03; @(negedge clk);
    wr_data = 8'h00; @(negedge clk);
    check("R4", "3->0 wrap step_in", int'(step_in), 1);
    wr_en = 1'b0; @(negedge clk);
    check("R7", "pulse ends", int'({step_in, step_out, led_changed}), 0);
    // R3 walk outward across wrap
    wr(8'h03);
    check("R3", "0->3 wrap step_out", int'(step_out), 1);
    wr(8'h02); wr(8'h01); wr(8'h00);
    check("R3", "1->0 step_out", int'(step_out), 1);
    idle(2);
    // R5 opposite and same phase
    wr(8'h02);
    check("R5", "0->2 no step", int'({step_in, step_out}), 0);
    wr(8'h02);
    check("R5", "same phase no step", int'({step_in, step_out}), 0);
    wr(8'h01);
    wr(8'h03);
    check("R5", "1->3 no step", int'({step_in, step_out}), 0);
    // R6 lamp toggle and R2 bit 4 cleared
    wr(8'h1B);
    check("R6", "lamp on pulse", int'({led_changed, led}), 3);
    check("R2", "bit4 cleared", int'(port_q), 8'h0B);
    wr(8'hFB);
    check("R6", "lamp steady", int'(led_changed), 0);
    check("R2", "high bits kept", int'(port_q), 8'hEB);
    wr(8'hF3);
    check("R6", "lamp off pulse", int'({led_changed, led}), 2);
    idle(3);
    check("R2", "hold without write", int'(port_q), 8'hE3);
    // reset mid-run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1", "reset again", int'(port_q), 0);
    // random traffic
    lfsr = 8'hA5;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_en = lfsr[6] | lfsr[2];
      wr_data = lfsr ^ 8'(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule